// File: doc/BRIEF.md
# Burst Word-Address Sequencer

This block produces the run of 16-bit word addresses for a single burst read. A load pulse captures a start word address, a burst kind (wrapped, linear or hybrid) and a wrap-size code. From the next cycle on, the block presents one address at a time on a valid/ready output stream. Wrapped bursts circle inside an aligned group of 8, 16 or 32 words. Linear bursts count upward with no limit. Hybrid bursts cover one whole aligned group in wrap order and then carry on linearly from the word just past that group.

Storage is organised in pages of 16 words (32 bytes). Whenever a linear-phase address that is the first word of a page appears, the block raises a one-cycle page request. An array controller can use it to start fetching the following page while the current one streams out. A stop pulse ends the burst.

Back-pressure rules: `out_valid` stays high from the cycle after a load until a stop. An address is consumed on each rising edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, `out_addr` holds its value. `out_ready` has no effect while `out_valid` is low.

Top module: `burst_addr_seq`

## Requirements
- R1: In the cycle after `load` is sampled high, `out_valid` is 1 and `out_addr` equals the captured `start_addr`, with no handshake needed.
- R2: While `out_valid` is 1 and `out_ready` is 0, with neither `load` nor `stop`, `out_addr` and `out_valid` keep their values into the next cycle.
- R3: `wrap_code` selects the group size: 00 = 32 words, 01 = 8 words, 10 = 16 words, and 11 = 16 words.
- R4: When `burst_mode` is 00 (wrapped), each accepted address is followed by the next word in the same aligned group. After the group's last word, the group's first word follows.
- R5: When `burst_mode` is 01, or the reserved value 11, each accepted address is followed by that address plus one, modulo 2^AW.
- R6: When `burst_mode` is 10 (hybrid), the first N addresses follow the wrapped order of R4, where N is the group size. Address N+1 is the first word above the group, and linear order follows from there.
- R7: The burst kind and group size come from the values sampled with each `load`. A new load restarts the sequence at once, even in the middle of a burst.
- R8: `page_req` is high for exactly the first cycle in which a linear-phase address with its low four bits equal to zero is presented. This includes a linear start address that is page-aligned. Wrap-phase addresses never raise it.
- R9: A `stop` without `load` makes `out_valid` 0 in the next cycle. When `load` and `stop` arrive together, the load wins.
- R10: After reset, `out_valid` and `page_req` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Captures start address, burst kind and group size |
| start_addr | input | AW | First word address of the burst |
| burst_mode | input | 2 | 00 wrapped, 01 linear, 10 hybrid, 11 linear |
| wrap_code | input | 2 | Group size code (see R3) |
| stop | input | 1 | Ends the burst |
| out_ready | input | 1 | Consumer accepts the presented address |
| out_valid | output | 1 | An address is presented |
| out_addr | output | AW | Presented word address |
| page_req | output | 1 | One-cycle request to fetch the next page |

## Verification
Several rules are checked by properties on every cycle: the first address after a load, the hold under back-pressure, the group bits staying fixed in a pure wrap burst, the plus-one step in linear bursts, page requests landing only on page-aligned valid addresses and lasting one cycle, and the drop of `out_valid` after a stop. Other behaviour needs whole sequences compared against an independent model, so only the bench scenarios show it. This covers the exact wrap order for each group size and each start offset, the exit point of hybrid bursts, the decoding of the reserved codes, counting across the top of the address space, and page requests at the hybrid switch.

// File: rtl/bas_pkg.sv
package bas_pkg;
  typedef enum logic [1:0] {
    BM_WRAP   = 2'b00,
    BM_LINEAR = 2'b01,
    BM_HYBRID = 2'b10,
    BM_RSVD   = 2'b11
  } burst_mode_e;

  typedef enum logic {
    PH_WRAP   = 1'b0,
    PH_LINEAR = 1'b1
  } phase_e;

  function automatic phase_e start_phase(input logic [1:0] mode);
    return (mode == BM_WRAP || mode == BM_HYBRID) ? PH_WRAP : PH_LINEAR;
  endfunction
endpackage

// File: rtl/bas_wrap_decode.sv
module bas_wrap_decode #(
  parameter int MAX_WRAP_WORDS = 32,
  localparam int WL = $clog2(MAX_WRAP_WORDS)
) (
  input  logic [1:0]    code,
  output logic [WL-1:0] mask
);
  localparam int LEN_FULL    = MAX_WRAP_WORDS;
  localparam int LEN_QUARTER = MAX_WRAP_WORDS / 4;
  localparam int LEN_HALF    = MAX_WRAP_WORDS / 2;

  always_comb begin
    unique case (code)
      2'b00:   mask = WL'(LEN_FULL - 1);
      2'b01:   mask = WL'(LEN_QUARTER - 1);
      default: mask = WL'(LEN_HALF - 1);
    endcase
  end
endmodule

// File: rtl/bas_next_addr.sv
module bas_next_addr
  import bas_pkg::*;
#(
  parameter int AW = 24,
  parameter int WL = 5
) (
  input  logic [AW-1:0] cur,
  input  logic [WL-1:0] mask,
  input  logic [WL-1:0] count,
  input  logic          hybrid,
  input  phase_e        phase,
  output logic [AW-1:0] next,
  output phase_e        next_phase
);
  logic [AW-1:0] mask_w;
  logic [AW-1:0] inc;
  logic [AW-1:0] wrapped;
  logic [AW-1:0] exit_addr;
  logic          wrap_done;

  assign mask_w    = {{(AW-WL){1'b0}}, mask};
  assign inc       = cur + AW'(1);
  assign wrapped   = (cur & ~mask_w) | (inc & mask_w);
  assign exit_addr = (cur | mask_w) + AW'(1);
  assign wrap_done = hybrid && (count == mask);

  always_comb begin
    if (phase == PH_LINEAR) begin
      next       = inc;
      next_phase = PH_LINEAR;
    end else if (wrap_done) begin
      next       = exit_addr;
      next_phase = PH_LINEAR;
    end else begin
      next       = wrapped;
      next_phase = PH_WRAP;
    end
  end
endmodule

// File: rtl/bas_page_detect.sv
module bas_page_detect
  import bas_pkg::*;
#(
  parameter int AW = 24,
  parameter int PAGE_LOG2 = 4
) (
  input  logic [AW-1:0] addr,
  input  phase_e        phase,
  output logic          hit
);
  assign hit = (phase == PH_LINEAR) && (addr[PAGE_LOG2-1:0] == '0);
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bas_pkg::*;
#(
  parameter int AW = 24,
  parameter int PAGE_WORDS = 16,
  parameter int MAX_WRAP_WORDS = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] start_addr,
  input  logic [1:0]    burst_mode,
  input  logic [1:0]    wrap_code,
  input  logic          stop,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [AW-1:0] out_addr,
  output logic          page_req
);
  localparam int PAGE_LOG2 = $clog2(PAGE_WORDS);
  localparam int WL = $clog2(MAX_WRAP_WORDS);

  logic [AW-1:0] cur_q;
  logic          valid_q;
  phase_e        phase_q;
  logic          hybrid_q;
  logic [WL-1:0] mask_q;
  logic [WL-1:0] cnt_q;
  logic          page_q;

  logic [WL-1:0] dec_mask;
  logic [AW-1:0] nxt_addr;
  phase_e        nxt_phase;
  logic [AW-1:0] cand_addr;
  phase_e        cand_phase;
  logic          cand_hit;
  logic          accept;

  bas_wrap_decode #(.MAX_WRAP_WORDS(MAX_WRAP_WORDS)) u_dec (
    .code (wrap_code),
    .mask (dec_mask)
  );

  bas_next_addr #(.AW(AW), .WL(WL)) u_next (
    .cur        (cur_q),
    .mask       (mask_q),
    .count      (cnt_q),
    .hybrid     (hybrid_q),
    .phase      (phase_q),
    .next       (nxt_addr),
    .next_phase (nxt_phase)
  );

  assign cand_addr  = load ? start_addr : nxt_addr;
  assign cand_phase = load ? start_phase(burst_mode) : nxt_phase;

  bas_page_detect #(.AW(AW), .PAGE_LOG2(PAGE_LOG2)) u_page (
    .addr  (cand_addr),
    .phase (cand_phase),
    .hit   (cand_hit)
  );

  assign accept = valid_q && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q    <= '0;
      valid_q  <= 1'b0;
      phase_q  <= PH_LINEAR;
      hybrid_q <= 1'b0;
      mask_q   <= '0;
      cnt_q    <= '0;
      page_q   <= 1'b0;
    end else if (load) begin
      cur_q    <= start_addr;
      valid_q  <= 1'b1;
      phase_q  <= cand_phase;
      hybrid_q <= (burst_mode == BM_HYBRID);
      mask_q   <= dec_mask;
      cnt_q    <= '0;
      page_q   <= cand_hit;
    end else if (stop) begin
      valid_q  <= 1'b0;
      page_q   <= 1'b0;
    end else if (accept) begin
      cur_q    <= nxt_addr;
      phase_q  <= nxt_phase;
      cnt_q    <= cnt_q + WL'(1);
      page_q   <= cand_hit;
    end else begin
      page_q   <= 1'b0;
    end
  end

  assign out_valid = valid_q;
  assign out_addr  = cur_q;
  assign page_req  = page_q;
endmodule

// File: rtl/bas_checker.sv
module bas_checker #(
  parameter int AW = 24,
  parameter int PAGE_LOG2 = 4,
  parameter int WL = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load,
  input logic          stop,
  input logic [AW-1:0] start_addr,
  input logic [1:0]    burst_mode,
  input logic          out_ready,
  input logic          out_valid,
  input logic [AW-1:0] out_addr,
  input logic          page_req,
  input logic [WL-1:0] wrap_mask
);
  logic [1:0]    mode_q;
  logic [AW-1:0] grp_mask;
  logic          step;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= 2'b01;
    else if (load) mode_q <= burst_mode;
  end

  assign grp_mask = ~{{(AW-WL){1'b0}}, wrap_mask};
  assign step = out_valid && out_ready && !load && !stop;

  p_load_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> out_valid && out_addr == $past(start_addr));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !load && !stop |=> out_valid && $stable(out_addr));

  p_wrap_group_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step && mode_q == 2'b00 |=> (out_addr & grp_mask) == $past(out_addr & grp_mask));

  p_linear_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step && mode_q[0] |=> out_addr == $past(out_addr) + AW'(1));

  p_page_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
    page_req |-> out_valid && out_addr[PAGE_LOG2-1:0] == '0);

  p_page_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    page_req && !load |=> !page_req);

  p_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop && !load |=> !out_valid);
endmodule

bind burst_addr_seq bas_checker #(.AW(AW), .PAGE_LOG2(PAGE_LOG2), .WL(WL)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .load       (load),
  .stop       (stop),
  .start_addr (start_addr),
  .burst_mode (burst_mode),
  .out_ready  (out_ready),
  .out_valid  (out_valid),
  .out_addr   (out_addr),
  .page_req   (page_req),
  .wrap_mask  (mask_q)
);

// File: tb/burst_addr_seq_bench.sv
`timescale 1ns/1ps
module burst_addr_seq_bench;
  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [1:0]    burst_mode = 2'b00;
  logic [1:0]    wrap_code = 2'b00;
  logic          stop = 1'b0;
  logic          out_ready = 1'b0;
  logic          out_valid;
  logic [AW-1:0] out_addr;
  logic          page_req;

  int checks = 0;
  int fails = 0;

  logic [AW-1:0] q_addr[$];
  bit            q_flag[$];
  string         q_tag[$];
  bit            seen_pg = 1'b0;

  always #2 clk = ~clk;

  burst_addr_seq #(.AW(AW)) u_burst_addr_seq (
    .clk(clk), .rst_n(rst_n), .load(load), .start_addr(start_addr),
    .burst_mode(burst_mode), .wrap_code(wrap_code), .stop(stop),
    .out_ready(out_ready), .out_valid(out_valid), .out_addr(out_addr),
    .page_req(page_req)
  );

  // Monitor: pops an expected item on every accepted address.
  always @(negedge clk) begin
    if (rst_n) begin
      if (load) seen_pg = 1'b0;
      else if (page_req) seen_pg = 1'b1;
      if (out_valid && out_ready && !load) begin
        if (q_addr.size() == 0) begin
          checks++; fails++;
          $display("FAIL R1 unexpected address %h, expected none", out_addr);
        end else begin
          logic [AW-1:0] ea;
          bit ef;
          string tg;
          ea = q_addr.pop_front();
          ef = q_flag.pop_front();
          tg = q_tag.pop_front();
          checks++;
          if (out_addr !== ea) begin
            fails++;
            $display("FAIL %s address actual %h expected %h", tg, out_addr, ea);
          end
          checks++;
          if (seen_pg !== ef) begin
            fails++;
            $display("FAIL R8 page request at %h actual %0d expected %0d", ea, seen_pg, ef);
          end
          seen_pg = 1'b0;
        end
      end
    end
  end

  // Driver: builds the expected sequence from R3..R8, then runs the burst.
  task automatic run_burst(input logic [AW-1:0] st, input logic [1:0] md,
                           input logic [1:0] wc, input int n, input int stall,
                           input bit stop_with_load);
    int len;
    logic [AW-1:0] a;
    logic [AW-1:0] m;
    bit lin;
    int acc;
    int cyc;
    string base;
    len = (wc == 2'b00) ? 32 : (wc == 2'b01) ? 8 : 16;   // R3
    m = AW'(len - 1);
    a = st;
    lin = md[0];                                          // R5: 01 and 11 linear
    base = (md == 2'b00) ? "R4 R3" : (md == 2'b10) ? "R6 R3" : "R5";
    for (int k = 0; k < n; k++) begin
      q_addr.push_back(a);
      q_flag.push_back(lin && a[3:0] == 4'h0);            // R8
      if (k == 0) q_tag.push_back(stop_with_load ? "R1 R9" : "R1 R7");
      else q_tag.push_back(stall != 0 ? {base, " R2"} : base);
      if (lin) a = a + 1'b1;
      else if (md == 2'b10 && k == len - 1) begin         // R6 exit
        a = (a | m) + 1'b1;
        lin = 1'b1;
      end else a = (a & ~m) | ((a + 1'b1) & m);
    end
    @(posedge clk); #1;
    load = 1'b1; start_addr = st; burst_mode = md; wrap_code = wc;
    out_ready = 1'b0; stop = stop_with_load;
    @(posedge clk); #1;
    load = 1'b0; stop = 1'b0;
    acc = 0; cyc = 0;
    while (acc < n) begin
      out_ready = (stall == 0) || (cyc % (stall + 1) != 0);
      cyc++;
      @(posedge clk); #1;
      if (out_ready) acc++;
    end
    out_ready = 1'b0; stop = 1'b1;
    @(posedge clk); #1;
    stop = 1'b0;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R9 out_valid after stop actual %b expected 0", out_valid);
    end
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || page_req !== 1'b0) begin
          fails++;
          $display("FAIL R10 reset valid=%b page=%b expected 0 0", out_valid, page_req);
        end
        // Every mode, every size code, every offset in a 32-word group.
        for (int md = 0; md < 4; md++)
          for (int wc = 0; wc < 4; wc++)
            for (int off = 0; off < 32; off++)
              run_burst(24'h0ABC00 + AW'(off) + AW'(md * 64), 2'(md), 2'(wc),
                        70, off % 3, 1'b0);
        // R5: counting across the top of the address space.
        run_burst(24'hFFFFFE, 2'b01, 2'b00, 4, 0, 1'b0);
        // R9: load wins over a simultaneous stop.
        run_burst(24'h000123, 2'b01, 2'b01, 5, 1, 1'b1);
        // R7: back-to-back bursts of different kinds reuse nothing.
        run_burst(24'h00045A, 2'b10, 2'b01, 20, 0, 1'b0);
        run_burst(24'h00045A, 2'b00, 2'b10, 20, 2, 1'b0);
        repeat (2) @(negedge clk);
        checks++;
        if (q_addr.size() != 0) begin
          fails++;
          $display("FAIL R1 leftover expected items actual %0d expected 0", q_addr.size());
        end
      end
      begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R1 watchdog expired actual hung expected done");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule